// File: doc/BRIEF.md
# VLIW Execute Packet Dispatcher

This block sits between program memory and instruction decode in a wide-issue processor front end. It takes in a fetch packet of eight 32-bit instruction words, arriving as one 256-bit word. It cuts the fetch packet into execute packets and issues one execute packet per clock. Bit 0 of each instruction word is a chain bit. When it is 1, the next word joins the same execute packet. When it is 0, the packet closes after that word.

An issued packet is presented on an eight-slot output vector in program order. Slot 0 carries the packet's first instruction. A mask marks the slots in use, and a start index gives the position of the first instruction within the fetch packet. The block accepts a new fetch packet only after the last execute packet of the current one has gone out. A stall input freezes issue in place. A flush input drops whatever remains and asks for new data in the same cycle.

Top module: `exec_packet_issuer`

## Requirements
- R1: After reset, `fp_ready` is 1 and `ep_valid` is 0.
- R2: A word whose bit 0 is 1 is followed by the next word in the same execute packet. A word whose bit 0 is 0 closes the packet, and the next word opens a new one.
- R3: Word 7 of a fetch packet always closes its execute packet, whatever its bit 0.
- R4: While `ep_valid` is 1, slot k of `ep_words` (bits 32k+31..32k) holds fetch word `ep_start`+k for each k below the packet length. `ep_mask` has exactly its low "length" bits set. Unused slots read zero. At most one packet issues per cycle.
- R5: `ep_start` gives the word index (0 to 7) of the packet's first instruction. The first packet of every fetch packet starts at 0, and each following packet starts right after the previous one ends.
- R6: `fp_ready` stays 0 from the accepting edge until the cycle after the last execute packet of that fetch packet has issued. It is 1 again from that cycle on.
- R7: While `stall` is 1, `ep_valid` is 0 and the issue position does not move. Issue resumes at the same packet once `stall` falls.
- R8: While `flush` is 1, `ep_valid` is 0 and `fp_ready` is 1. The unissued rest of the held fetch packet is discarded.
- R9: A fetch packet is taken on a clock edge with `fp_valid` and `fp_ready` both 1. Its first execute packet is offered in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fp_valid | input | 1 | Fetch packet present on `fp_data` |
| fp_ready | output | 1 | Dispatcher can take a fetch packet |
| fp_data | input | 256 | Fetch packet, word i in bits 32i+31..32i |
| stall | input | 1 | Hold issue position, issue nothing |
| flush | input | 1 | Drop the remaining packets, request new data |
| ep_valid | output | 1 | An execute packet is issued this cycle |
| ep_mask | output | 8 | Occupied slots of the issued packet |
| ep_words | output | 256 | Issued instructions, slot 0 first |
| ep_start | output | 3 | Word index of the first issued instruction |

## Verification
The bench builds the block with its defaults: eight slots of 32 bits. At that size both extremes fit in one fetch packet. One extreme is eight single-word execute packets. The other is a single packet spanning all eight words, closed only by the forced boundary at word 7. It also exercises mixed lengths. It covers a stall applied on the first issue cycle and a flush in the middle of a fetch packet, followed by a clean reload.

// File: rtl/exec_packet_issuer.sv
module exec_packet_issuer #(
  parameter int SLOTS = 8,
  parameter int IW = 32,
  localparam int PW = $clog2(SLOTS),
  localparam int FW = SLOTS * IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fp_valid,
  output logic          fp_ready,
  input  logic [FW-1:0] fp_data,
  input  logic          stall,
  input  logic          flush,
  output logic          ep_valid,
  output logic [SLOTS-1:0] ep_mask,
  output logic [FW-1:0] ep_words,
  output logic [PW-1:0] ep_start
);

  logic [FW-1:0] fp_q;
  logic          held_q;
  logic [PW-1:0] pos_q;
  logic [PW-1:0] last;
  logic          found;
  logic [PW:0]   len;

  assign ep_valid = held_q & ~stall & ~flush;
  assign fp_ready = ~held_q | flush;
  assign ep_start = pos_q;

  always_comb begin
    last  = PW'(SLOTS - 1);
    found = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (!found && PW'(i) >= pos_q && (!fp_q[i*IW] || i == SLOTS - 1)) begin
        last  = PW'(i);
        found = 1'b1;
      end
    end
  end

  assign len = {1'b0, last} - {1'b0, pos_q} + (PW+1)'(1);

  always_comb begin
    for (int k = 0; k < SLOTS; k++) begin
      ep_mask[k] = ep_valid && ((PW+1)'(k) < len);
      ep_words[k*IW +: IW] = ep_mask[k] ? fp_q[(int'(pos_q) + k)*IW +: IW] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (fp_valid && fp_ready) fp_q <= fp_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      pos_q  <= '0;
    end else if (fp_valid && fp_ready) begin
      held_q <= 1'b1;
      pos_q  <= '0;
    end else if (flush) begin
      held_q <= 1'b0;
    end else if (ep_valid) begin
      if (last == PW'(SLOTS - 1)) held_q <= 1'b0;
      else pos_q <= last + PW'(1);
    end
  end

endmodule

// File: rtl/exec_packet_issuer_chk.sv
module exec_packet_issuer_chk #(
  parameter int SLOTS = 8,
  parameter int IW = 32,
  localparam int PW = $clog2(SLOTS),
  localparam int FW = SLOTS * IW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fp_valid,
  input logic          fp_ready,
  input logic          stall,
  input logic          flush,
  input logic          ep_valid,
  input logic [SLOTS-1:0] ep_mask,
  input logic [PW-1:0] ep_start
);

  AST_MASK_LOW_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ep_valid |-> (ep_mask[0] && ((ep_mask & (ep_mask + 1'b1)) == '0))); // R4
  AST_NO_FETCH_MID: assert property (@(posedge clk) disable iff (!rst_n)
    ep_valid |-> !fp_ready); // R6
  AST_STALL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !ep_valid); // R7
  AST_FLUSH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (fp_ready && !ep_valid)); // R8
  AST_START_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_valid && $past(ep_valid) && $past(rst_n)) |->
      (ep_start == PW'(int'($past(ep_start)) + $countones($past(ep_mask))))); // R5
  AST_FRESH_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_valid && fp_ready) |=> (ep_start == '0)); // R9

endmodule

bind exec_packet_issuer exec_packet_issuer_chk #(.SLOTS(SLOTS), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fp_valid(fp_valid), .fp_ready(fp_ready),
  .stall(stall), .flush(flush), .ep_valid(ep_valid), .ep_mask(ep_mask),
  .ep_start(ep_start)
);

// File: tb/test_exec_packet_issuer.sv
module test_exec_packet_issuer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, fp_valid = 1'b0, stall = 1'b0, flush = 1'b0;
  logic [255:0] fp_data = '0;
  logic fp_ready, ep_valid;
  logic [7:0] ep_mask;
  logic [255:0] ep_words;
  logic [2:0] ep_start;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exec_packet_issuer i_exec_packet_issuer (
    .clk(clk), .rst_n(rst_n), .fp_valid(fp_valid), .fp_ready(fp_ready),
    .fp_data(fp_data), .stall(stall), .flush(flush), .ep_valid(ep_valid),
    .ep_mask(ep_mask), .ep_words(ep_words), .ep_start(ep_start));

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] mk(input int n, input logic [7:0] chain);
    logic [255:0] f;
    for (int i = 0; i < 8; i++) f[i*32 +: 32] = 32'hC000_0000 | 32'(n << 12) | 32'(i << 4) | {31'b0, chain[i]};
    return f;
  endfunction

  function automatic int ep_end(input logic [255:0] f, input int p);
    for (int i = p; i < 8; i++) if (!f[i*32] || i == 7) return i;
    return 7;
  endfunction

  task automatic step_in;
    @(negedge clk);
  endtask

  task automatic load(input logic [255:0] f);
    step_in();
    fp_valid = 1'b1; fp_data = f;
    #1 chk(fp_ready === 1'b1, "R6 ready when empty", {255'b0, fp_ready}, 256'd1);
    step_in();
    fp_valid = 1'b0;
  endtask

  task automatic check_issue(input logic [255:0] f, input int p, output int e);
    logic [255:0] ew;
    logic [7:0] em;
    e = ep_end(f, p);
    ew = '0; em = '0;
    for (int k = 0; k <= e - p; k++) begin
      em[k] = 1'b1;
      ew[k*32 +: 32] = f[(p+k)*32 +: 32];
    end
    #1;
    chk(ep_valid === 1'b1, "R9 issue valid", {255'b0, ep_valid}, 256'd1);
    chk(ep_start === 3'(p), "R5 start index", {253'b0, ep_start}, 256'(p));
    chk(ep_mask === em, "R2 R3 mask", {248'b0, ep_mask}, {248'b0, em});
    chk(ep_words === ew, "R4 slot words", ep_words, ew);
    chk(fp_ready === 1'b0, "R6 no fetch mid packet", {255'b0, fp_ready}, 256'd0);
  endtask

  task automatic run_from(input logic [255:0] f, input int p0);
    int p = p0, e;
    forever begin
      check_issue(f, p, e);
      if (e == 7) break;
      p = e + 1;
      step_in();
    end
    step_in();
    #1;
    chk(fp_ready === 1'b1, "R6 ready after last", {255'b0, fp_ready}, 256'd1);
    chk(ep_valid === 1'b0, "R6 idle after last", {255'b0, ep_valid}, 256'd0);
  endtask

  task automatic t_reset;
    repeat (2) step_in();
    #1;
    chk(fp_ready === 1'b1, "R1 ready in reset", {255'b0, fp_ready}, 256'd1);
    chk(ep_valid === 1'b0, "R1 no issue in reset", {255'b0, ep_valid}, 256'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_full(input logic [255:0] f);
    load(f);
    run_from(f, 0);
  endtask

  task automatic t_stall;
    logic [255:0] f = mk(7, 8'b0001_0011);
    int e;
    load(f);
    stall = 1'b1;
    for (int c = 0; c < 3; c++) begin
      #1 chk(ep_valid === 1'b0, "R7 stalled", {255'b0, ep_valid}, 256'd0);
      chk(fp_ready === 1'b0, "R7 no fetch while stalled", {255'b0, fp_ready}, 256'd0);
      step_in();
    end
    stall = 1'b0;
    run_from(f, 0);
    e = 0;
  endtask

  task automatic t_flush;
    logic [255:0] f = mk(8, 8'b0000_0101);
    logic [255:0] g = mk(9, 8'b1000_0000);
    int e;
    load(f);
    check_issue(f, 0, e);
    step_in();
    flush = 1'b1;
    #1 chk(ep_valid === 1'b0, "R8 no issue on flush", {255'b0, ep_valid}, 256'd0);
    chk(fp_ready === 1'b1, "R8 ready on flush", {255'b0, fp_ready}, 256'd1);
    step_in();
    flush = 1'b0;
    #1 chk(ep_valid === 1'b0, "R8 rest discarded", {255'b0, ep_valid}, 256'd0);
    chk(fp_ready === 1'b1, "R8 still requesting", {255'b0, fp_ready}, 256'd1);
    t_full(g);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_full(mk(1, 8'b0000_0000));
    t_full(mk(2, 8'b1111_1111));
    t_full(mk(3, 8'b0111_0110));
    t_full(mk(4, 8'b0111_1111));
    t_full(mk(5, 8'b1010_1010));
    t_stall();
    t_flush();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule